// File: doc/BRIEF.md
# Programmable Event Counter Unit

This block holds a small bank of programmable event counters for on-chip performance measurement. Each counter carries its own selection register: an 8-bit event code, an 8-bit qualifier and a local run bit. The code and qualifier pair is decoded onto one of several single-cycle event strobes that other logic drives into the block. A counter advances by one on every clock in which its decoded strobe is high, its local run bit is set and its bit in the shared run mask is set.

Software preloads a counter with a negative value, so that it wraps after the wanted number of events. When a counter wraps from all ones to zero, the block records this in a shared overflow register and raises an interrupt request. The handler clears the run mask, reads the overflow register and writes a clear mask. The clear mask takes effect only while the run mask is non-zero. The top bit of the overflow register is a separate "configuration changed" flag. It is set by an input pulse, is cleared through the same clear mask, and never raises the interrupt.

All registers are 64 bits wide on a simple word bus. A write is applied at the next clock edge. Read data is registered from the address, so it appears one cycle after the address is presented.

Top module: `pmc_unit`

## Requirements
- R1: After reset, every counter, the run mask, the selection registers and the overflow register read zero, and `irq_o` is low.
- R2: A counter increments by exactly one on each clock edge where its decoded strobe is high, its local run bit (selection bit 16) is set and its run-mask bit is set. If any of the three is low, it holds its value.
- R3: Selection bits [7:0] hold the event code and bits [15:8] the qualifier. The pairs decode to strobes as follows: 82h/00h to `evt_i[0]` (core clocks), 00h/00h to `evt_i[1]` (retired instructions), 28h/00h to `evt_i[2]` (retired branches), 29h/00h to `evt_i[3]` (mispredicted branches) and 83h/00h to `evt_i[4]` (bus clocks). Any other pair counts nothing.
- R4: A counter that increments from all ones wraps to zero and sets overflow bit n, where n is the counter index.
- R5: `irq_o` is high exactly while any of overflow bits 0 to NUM_CTR-1 is set, and it stays high until those bits are cleared.
- R6: Writing a mask to the clear address clears the matching overflow bits only while the run mask is non-zero. When the run mask is zero, the write leaves the overflow register unchanged.
- R7: A pulse on `cfg_chg_i` sets overflow bit 63. That bit is cleared by clear-mask bit 63 under the rule of R6, and it never drives `irq_o`.
- R8: A wrap, or a `cfg_chg_i` pulse, in the same cycle as a clear of the same bit leaves that bit set.
- R9: Word addresses: counters at 0 to 3, selections at 4 to 7, run mask at 8, overflow register at 9, clear mask at 10 (reads zero). Counters keep only the low 48 bits of a write. The run mask keeps bits [3:0]. Read data returns on the edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| evt_i | input | 5 | Event strobes, one per decoded event |
| cfg_chg_i | input | 1 | Configuration-changed pulse, sets overflow bit 63 |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A bad selection decode or a wrong gating term shows up as a wrong counter value on the first read after the event burst. The bench reads every counter back after each burst, so such an error appears within a few cycles of the burst. A wrap that fails to record, or a clear that wrongly takes effect while the run mask is zero, is visible on `irq_o` on the very next edge, and the following read of the overflow register shows it as well. A set-versus-clear collision is staged in a single cycle, so losing the overflow bit drops `irq_o` at once.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int EVT_CNT = 5;
   localparam int EVT_IDX_W = $clog2(EVT_CNT);
   localparam int SEL_CODE_LSB = 0;
   localparam int SEL_QUAL_LSB = 8;
   localparam int SEL_RUN_BIT = 16;
   localparam int SEL_W = SEL_RUN_BIT + 1;

   typedef enum logic [EVT_IDX_W-1:0] {
      EV_CORE_CLK = 3'd0,
      EV_INSTR    = 3'd1,
      EV_BRANCH   = 3'd2,
      EV_BR_MISS  = 3'd3,
      EV_BUS_CLK  = 3'd4
   } evt_id_e;

   typedef struct packed {
      logic    hit;
      evt_id_e id;
   } evt_dec_t;

   function automatic evt_dec_t decode_evt(input logic [7:0] code, input logic [7:0] qual);
      evt_dec_t d;
      d.hit = 1'b1;
      d.id  = EV_CORE_CLK;
      case ({code, qual})
         16'h8200: d.id = EV_CORE_CLK;
         16'h0000: d.id = EV_INSTR;
         16'h2800: d.id = EV_BRANCH;
         16'h2900: d.id = EV_BR_MISS;
         16'h8300: d.id = EV_BUS_CLK;
         default:  d.hit = 1'b0;
      endcase
      return d;
   endfunction
endpackage

// File: rtl/pmc_evt_sel.sv
module pmc_evt_sel
   import pmc_pkg::*;
(
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [EVT_CNT-1:0] evt_i,
   output logic               strobe_o
);
   evt_dec_t dec;

   always_comb begin
      dec = decode_evt(sel_i[SEL_CODE_LSB +: 8], sel_i[SEL_QUAL_LSB +: 8]);
      strobe_o = dec.hit & evt_i[dec.id] & sel_i[SEL_RUN_BIT];
   end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int CTR_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTR_W-1:0] wr_data,
   input  logic             inc,
   output logic [CTR_W-1:0] cnt_o,
   output logic             wrap_o
);
   if (CTR_W < 2) begin : g_bad_w
      $error("pmc_counter: CTR_W must be at least 2");
   end

   logic [CTR_W-1:0] cnt_q;

   assign wrap_o = inc & ~wr_en & (&cnt_q);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wr_en)
         cnt_q <= wr_data;
      else if (inc)
         cnt_q <= cnt_q + 1'b1;
   end

   // R2: idle counter holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr_en) |=> (cnt_q == $past(cnt_q)));
   // R2: enabled counter steps by one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
   parameter int NUM_CTR = 4,
   parameter int DATA_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CTR-1:0] wrap_i,
   input  logic              cc_set_i,
   input  logic              clr_we_i,
   input  logic [DATA_W-1:0] clr_mask_i,
   input  logic              run_any_i,
   output logic [DATA_W-1:0] sts_o,
   output logic              irq_o
);
   if (NUM_CTR > DATA_W - 1) begin : g_bad_n
      $error("pmc_status: NUM_CTR must leave the top bit free");
   end

   logic [NUM_CTR-1:0] ovf_q;
   logic               cc_q;
   logic               clr_go;
   logic [NUM_CTR-1:0] ovf_clr;

   assign clr_go  = clr_we_i & run_any_i;
   assign ovf_clr = clr_go ? clr_mask_i[NUM_CTR-1:0] : '0;
   assign irq_o   = |ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= '0;
         cc_q  <= 1'b0;
      end else begin
         ovf_q <= (ovf_q & ~ovf_clr) | wrap_i;
         cc_q  <= (cc_q & ~(clr_go & clr_mask_i[DATA_W-1])) | cc_set_i;
      end
   end

   always_comb begin
      sts_o = '0;
      sts_o[NUM_CTR-1:0] = ovf_q;
      sts_o[DATA_W-1] = cc_q;
   end

   // R4: a wrap is recorded on the next edge
   p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|wrap_i) |=> irq_o);
   // R6: a clear while the run mask is zero drops no bit
   p_clr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && !run_any_i) |=> (($past(sts_o) & ~sts_o) == '0));
   // R5: the request holds until a clear that can act
   p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(clr_we_i && run_any_i)) |=> irq_o);
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 48,
   parameter int DATA_W  = 64,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [EVT_CNT-1:0] evt_i,
   input  logic              cfg_chg_i,
   output logic              irq_o
);
   localparam int A_SEL  = NUM_CTR;
   localparam int A_RUN  = 2 * NUM_CTR;
   localparam int A_STS  = A_RUN + 1;
   localparam int A_CLR  = A_RUN + 2;

   if (CTR_W > DATA_W) begin : g_bad_cw
      $error("pmc_unit: CTR_W exceeds DATA_W");
   end
   if (A_CLR >= (1 << ADDR_W)) begin : g_bad_aw
      $error("pmc_unit: ADDR_W too small for the register map");
   end
   if (SEL_W > DATA_W) begin : g_bad_sw
      $error("pmc_unit: selection field wider than data");
   end

   logic [NUM_CTR-1:0] run_q;
   logic [SEL_W-1:0]   sel_q [NUM_CTR];
   logic [CTR_W-1:0]   cnt   [NUM_CTR];
   logic [NUM_CTR-1:0] wrap;
   logic [NUM_CTR-1:0] strobe;
   logic [DATA_W-1:0]  sts;
   logic [DATA_W-1:0]  rd_mux;
   logic               clr_we;

   assign clr_we = reg_we && (reg_addr == ADDR_W'(A_CLR));

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (reg_we && reg_addr == ADDR_W'(A_RUN))
         run_q <= reg_wdata[NUM_CTR-1:0];
   end

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic ctr_we;

      assign ctr_we = reg_we && (reg_addr == ADDR_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)
            sel_q[i] <= '0;
         else if (reg_we && reg_addr == ADDR_W'(A_SEL + i))
            sel_q[i] <= reg_wdata[SEL_W-1:0];
      end

      pmc_evt_sel u_sel (
         .sel_i    (sel_q[i]),
         .evt_i    (evt_i),
         .strobe_o (strobe[i])
      );

      pmc_counter #(.CTR_W(CTR_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (ctr_we),
         .wr_data (reg_wdata[CTR_W-1:0]),
         .inc     (strobe[i] & run_q[i]),
         .cnt_o   (cnt[i]),
         .wrap_o  (wrap[i])
      );
   end

   pmc_status #(.NUM_CTR(NUM_CTR), .DATA_W(DATA_W)) u_sts (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrap_i     (wrap),
      .cc_set_i   (cfg_chg_i),
      .clr_we_i   (clr_we),
      .clr_mask_i (reg_wdata),
      .run_any_i  (|run_q),
      .sts_o      (sts),
      .irq_o      (irq_o)
   );

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (reg_addr == ADDR_W'(i))
            rd_mux = DATA_W'(cnt[i]);
         if (reg_addr == ADDR_W'(A_SEL + i))
            rd_mux = DATA_W'(sel_q[i]);
      end
      if (reg_addr == ADDR_W'(A_RUN))
         rd_mux = DATA_W'(run_q);
      if (reg_addr == ADDR_W'(A_STS))
         rd_mux = sts;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         reg_rdata <= '0;
      else
         reg_rdata <= rd_mux;
   end

   // R7: the configuration flag never raises the request
   p_cc_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chg_i && !irq_o && !(|wrap)) |=> !irq_o);
   // R2: a cleared run mask freezes every counter
   p_run_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == '0) |-> (wrap == '0));
endmodule

// File: tb/sim_pmc_unit.sv
module sim_pmc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [4:0]  evt_i = '0;
   logic        cfg_chg_i = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [3:0] A_RUN = 4'd8, A_STS = 4'd9, A_CLR = 4'd10;
   localparam logic [47:0] ONES = '1;

   // {code, qualifier, strobe mask, cycles, expected count}
   localparam logic [39:0] TBL [9] = '{
      40'h82_00_01_05_05, 40'h00_00_02_03_03, 40'h28_00_04_04_04,
      40'h29_00_08_02_02, 40'h83_00_10_06_06, 40'h82_01_01_05_00,
      40'h28_00_08_04_00, 40'h55_00_1F_03_00, 40'h00_00_1F_07_07 };

   pmc_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
      .cfg_chg_i(cfg_chg_i), .irq_o(irq_o));

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic burst(input logic [4:0] m, input int n);
      @(negedge clk);
      evt_i = m;
      repeat (n) @(negedge clk);
      evt_i = '0;
   endtask

   function automatic logic [63:0] selv(input logic [7:0] c, input logic [7:0] q, input logic en);
      return {47'b0, en, q, c};
   endfunction

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 10; i++) begin
         rd(4'(i), v);
         chk("R1 reset register", v, 64'd0);
      end
      chk("R1 reset irq", {63'd0, irq_o}, 64'd0);

      // R3 R2: decode table on counter 0
      for (int i = 0; i < 9; i++) begin
         logic [39:0] e;
         e = TBL[i];
         wr(4'd0, 64'd0);
         wr(4'd4, selv(e[39:32], e[31:24], 1'b1));
         wr(A_RUN, 64'd1);
         burst(e[23:16], int'(e[15:8]));
         wr(A_RUN, 64'd0);
         rd(4'd0, v);
         chk("R3 decode count", v, {56'd0, e[7:0]});
      end

      // R9: widths and map
      wr(4'd3, 64'hABCD_1234_5678_9ABC);
      rd(4'd3, v);
      chk("R9 counter width", v, 64'h0000_1234_5678_9ABC);
      wr(A_RUN, 64'hFF);
      rd(A_RUN, v);
      chk("R9 run mask width", v, 64'hF);
      wr(A_RUN, 64'd0);
      rd(A_CLR, v);
      chk("R9 clear reads zero", v, 64'd0);

      // R2: local and global gating
      wr(4'd1, 64'd0);
      wr(4'd5, selv(8'h82, 8'h00, 1'b0));
      wr(A_RUN, 64'd2);
      burst(5'h01, 4);
      rd(4'd1, v);
      chk("R2 local run off", v, 64'd0);
      wr(4'd5, selv(8'h82, 8'h00, 1'b1));
      wr(A_RUN, 64'd1);
      burst(5'h01, 4);
      rd(4'd1, v);
      chk("R2 global bit off", v, 64'd0);
      wr(A_RUN, 64'd2);
      burst(5'h01, 3);
      rd(4'd1, v);
      chk("R2 both on", v, 64'd3);

      // R4 R5: wrap
      wr(4'd1, {16'd0, 48'hFFFF_FFFF_FFFE});
      burst(5'h01, 2);
      wr(A_RUN, 64'd0);
      rd(4'd1, v);
      chk("R4 wrapped to zero", v, 64'd0);
      rd(A_STS, v);
      chk("R4 overflow bit 1", v, 64'd2);
      chk("R5 irq high", {63'd0, irq_o}, 64'd1);

      // R6: clear gated by run mask
      wr(A_CLR, 64'd2);
      rd(A_STS, v);
      chk("R6 clear ignored at zero run", v, 64'd2);
      chk("R5 irq held", {63'd0, irq_o}, 64'd1);
      wr(4'd4, selv(8'h00, 8'h00, 1'b0));
      wr(A_RUN, 64'd1);
      wr(A_CLR, 64'd2);
      chk("R6 irq low after clear", {63'd0, irq_o}, 64'd0);
      rd(A_STS, v);
      chk("R6 clear applied", v, 64'd0);

      // R7: configuration-changed flag
      @(negedge clk); cfg_chg_i = 1'b1;
      @(negedge clk); cfg_chg_i = 1'b0;
      chk("R7 no irq", {63'd0, irq_o}, 64'd0);
      rd(A_STS, v);
      chk("R7 bit 63 set", v, 64'h8000_0000_0000_0000);
      wr(A_CLR, 64'h8000_0000_0000_0000);
      rd(A_STS, v);
      chk("R7 bit 63 cleared", v, 64'd0);

      // R8: wrap coincident with clear
      wr(4'd6, selv(8'h82, 8'h00, 1'b1));
      wr(4'd2, {16'd0, ONES});
      wr(A_RUN, 64'd4);
      burst(5'h01, 1);
      rd(A_STS, v);
      chk("R8 first wrap", v, 64'd4);
      wr(4'd2, {16'd0, ONES});
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = 64'd4; evt_i = 5'h01;
      @(negedge clk);
      reg_we = 1'b0; evt_i = '0;
      chk("R8 irq stays", {63'd0, irq_o}, 64'd1);
      rd(A_STS, v);
      chk("R8 set wins", v, 64'd4);
      wr(A_CLR, 64'd4);
      rd(A_STS, v);
      chk("R6 final clear", v, 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule